// File: doc/BRIEF.md
# Single-Buffer Instruction Prefetch Unit

This block sits between a small stack-machine core and a slow single-port memory. It keeps a program pointer (`pc`) that always names the next cell to be executed, and while the current cell runs it reads that next cell into a one-word prefetch buffer. When the core asks for the next cell, the buffered word is copied into the instruction latch. When the core asks for an in-line literal, the same buffered word goes to the core's data path instead, and sequential prefetch moves on to the following address.

Data reads, data writes and jumps have no separate buffer. When one of them arrives while a prefetch is in flight, the unit aborts that memory cycle. It then runs the requested access through the one buffer. After that it restarts sequential prefetch from `pc`, or from the jump target for a jump. The memory side allows one outstanding request. Each request carries a tag, and an acknowledge whose tag is not the one expected is dropped. The core observes the same values it would observe if every cell were fetched only on demand.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high, `pc` is 0, `ir_load` and `rsp_valid` are 0 and `cmd_ready` is 0. After reset the first memory request reads address 0, and that word is loaded into the instruction latch without any command, leaving `pc` at 1.
- R2: Command code 0 (next cell) loads the word at `pc` into `ir_word` with a one-cycle `ir_load` pulse and advances `pc` by one. `ir_load` and `rsp_valid` never pulse in the same cycle, and `pc` does not change while the unit is idle with no command.
- R3: Command code 1 (literal) returns the word at `pc` on `rsp_data` with a one-cycle `rsp_valid` pulse, advances `pc` by one and leaves `ir_word` unchanged.
- R4: Command code 2 (data read) returns the word at `cmd_addr` on `rsp_data` with a `rsp_valid` pulse and leaves `pc` unchanged. The next cell command still delivers the word at `pc`.
- R5: Command code 3 (data write) writes `cmd_wdata` to `cmd_addr` and pulses `rsp_valid` once the memory acknowledges. A later next-cell or literal command returns the new content, even when the written address was already prefetched or being prefetched.
- R6: Command code 4 (jump) sets `pc` to `cmd_addr`, loads the word at that address into the instruction latch with an `ir_load` pulse, and leaves `pc` at target plus one.
- R7: At most one memory request is outstanding. A new request is issued only when no request is pending.
- R8: A read, write or jump accepted while a prefetch is outstanding raises `mem_abort` for exactly one cycle with no request in that cycle. The replacement request follows in the next cycle.
- R9: An acknowledge whose `mem_ack_tag` differs from the tag of the outstanding request has no effect on any result.
- R10: Command codes 5 to 7 are accepted and have no effect. No pulse appears on `ir_load` or `rsp_valid`, and `pc` and `ir_word` stay the same.
- R11: After each delivery the unit reads the new `pc` on its own. When the next-cell command arrives after that read has completed, `ir_load` follows two clock edges after the command is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Core presents a command |
| cmd_ready | output | 1 | Unit accepts a command this cycle |
| cmd_op | input | 3 | Command code (0 next, 1 literal, 2 read, 3 write, 4 jump) |
| cmd_addr | input | AW | Data address or jump target |
| cmd_wdata | input | DW | Write data |
| ir_load | output | 1 | Instruction latch updated this cycle |
| ir_word | output | DW | Instruction latch contents |
| rsp_valid | output | 1 | Literal, read or write completed |
| rsp_data | output | DW | Literal or read data |
| pc | output | AW | Address of the next cell |
| mem_req | output | 1 | Memory request issued this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Request write data |
| mem_tag | output | TW | Tag of the request |
| mem_abort | output | 1 | Drop the outstanding request |
| mem_ack | input | 1 | Memory completes a request |
| mem_ack_tag | input | TW | Tag of the completed request |
| mem_rdata | input | DW | Read data with the acknowledge |

## Verification
The bench builds the unit with a 6-bit address, an 8-bit word and a 2-bit tag, so one 64-word memory covers the whole address space. With that size the bench can jump to every address, read every address, and write and read back every address. Idle gaps of zero to eight cycles before each command place the request both before the prefetch is issued, while it is in flight, and after the buffer has filled. This reaches every abort path and the write-over-prefetched-word case. The memory model adds 3 to 5 cycles of latency and sends a stale acknowledge with the old tag two cycles after every abort, so the tag filter is exercised on each abort.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [2:0] {
        OP_NEXT  = 3'd0,
        OP_LIT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_JUMP  = 3'd4
    } fetch_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAITBUF,
        ST_DATA,
        ST_DRESP
    } fetch_st_e;

    // commands that take the memory port away from sequential prefetch
    function automatic logic takes_port(input logic [2:0] op);
        return (op == OP_READ) || (op == OP_WRITE) || (op == OP_JUMP);
    endfunction

endpackage

// File: rtl/pf_mem_port.sv
module pf_mem_port #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic          issue_we,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] issue_wdata,
    input  logic          abort,
    input  logic          mem_ack,
    input  logic [TW-1:0] mem_ack_tag,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [TW-1:0] mem_tag,
    output logic          mem_abort,
    output logic          busy,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    logic          busy_q;
    logic [TW-1:0] tag_q;
    logic [TW-1:0] expect_q;

    assign mem_req   = issue;
    assign mem_we    = issue_we;
    assign mem_addr  = issue_addr;
    assign mem_wdata = issue_wdata;
    assign mem_tag   = tag_q;
    assign mem_abort = abort;

    assign busy     = busy_q;
    assign hit      = busy_q && mem_ack && (mem_ack_tag == expect_q) && !abort;
    assign hit_data = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            tag_q    <= '0;
            expect_q <= '0;
        end else begin
            if (abort || hit) begin
                busy_q <= 1'b0;
            end
            if (issue) begin
                busy_q   <= 1'b1;
                expect_q <= tag_q;
                tag_q    <= tag_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pf_buffer.sv
module pf_buffer #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fill,
    input  logic          park,
    input  logic          drop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] word,
    output logic          valid
);

    logic [DW-1:0] word_q;
    logic          valid_q;

    assign word  = word_q;
    assign valid = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (fill || park) begin
                word_q <= din;
            end
            if (fill) begin
                valid_q <= 1'b1;
            end else if (drop || park) begin
                valid_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import fetch_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    input  logic          buf_valid,
    input  logic [DW-1:0] buf_word,
    input  logic          busy,
    input  logic          hit,
    output logic          issue,
    output logic          issue_we,
    output logic [AW-1:0] issue_addr,
    output logic [DW-1:0] issue_wdata,
    output logic          abort,
    output logic          buf_fill,
    output logic          buf_park,
    output logic          buf_drop,
    output logic          ir_load,
    output logic [DW-1:0] ir_word,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] pc
);

    fetch_st_e     st_q;
    logic [AW-1:0] pc_q;
    logic          lit_q;
    logic          wr_q;
    logic [AW-1:0] daddr_q;
    logic [DW-1:0] dwdata_q;
    logic [DW-1:0] ir_q;
    logic          ir_load_q;
    logic          rsp_valid_q;
    logic [DW-1:0] rsp_data_q;

    logic accept;
    logic redirect;
    logic pf_issue;
    logic d_issue;

    assign accept    = (st_q == ST_IDLE) && cmd_valid;
    assign redirect  = accept && takes_port(cmd_op);
    assign cmd_ready = (st_q == ST_IDLE);
    assign abort     = redirect && busy;

    assign pf_issue = ((st_q == ST_IDLE) || (st_q == ST_WAITBUF))
                      && !busy && !buf_valid && !redirect;
    assign d_issue  = (st_q == ST_DATA) && !busy;

    assign issue       = (pf_issue || d_issue) && !rst;
    assign issue_we    = d_issue && wr_q;
    assign issue_addr  = d_issue ? daddr_q : pc_q;
    assign issue_wdata = dwdata_q;

    assign buf_fill = hit && (st_q != ST_DATA);
    assign buf_park = hit && (st_q == ST_DATA);
    assign buf_drop = ((st_q == ST_WAITBUF) && buf_valid) || redirect;

    assign ir_load   = ir_load_q;
    assign ir_word   = ir_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign pc        = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_WAITBUF;
            pc_q        <= '0;
            lit_q       <= 1'b0;
            wr_q        <= 1'b0;
            daddr_q     <= '0;
            dwdata_q    <= '0;
            ir_q        <= '0;
            ir_load_q   <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            ir_load_q   <= 1'b0;
            rsp_valid_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (cmd_op)
                            OP_NEXT: begin
                                lit_q <= 1'b0;
                                st_q  <= ST_WAITBUF;
                            end
                            OP_LIT: begin
                                lit_q <= 1'b1;
                                st_q  <= ST_WAITBUF;
                            end
                            OP_READ, OP_WRITE: begin
                                daddr_q  <= cmd_addr;
                                dwdata_q <= cmd_wdata;
                                wr_q     <= (cmd_op == OP_WRITE);
                                st_q     <= ST_DATA;
                            end
                            OP_JUMP: begin
                                pc_q  <= cmd_addr;
                                lit_q <= 1'b0;
                                st_q  <= ST_WAITBUF;
                            end
                            default: st_q <= ST_IDLE;
                        endcase
                    end
                end
                ST_WAITBUF: begin
                    if (buf_valid) begin
                        pc_q <= pc_q + 1'b1;
                        if (lit_q) begin
                            rsp_valid_q <= 1'b1;
                            rsp_data_q  <= buf_word;
                        end else begin
                            ir_q      <= buf_word;
                            ir_load_q <= 1'b1;
                        end
                        st_q <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (hit) begin
                        st_q <= ST_DRESP;
                    end
                end
                ST_DRESP: begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= buf_word;
                    st_q        <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          ir_load,
    output logic [DW-1:0] ir_word,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] pc,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [TW-1:0] mem_tag,
    output logic          mem_abort,
    input  logic          mem_ack,
    input  logic [TW-1:0] mem_ack_tag,
    input  logic [DW-1:0] mem_rdata
);

    logic          issue;
    logic          issue_we;
    logic [AW-1:0] issue_addr;
    logic [DW-1:0] issue_wdata;
    logic          abort;
    logic          busy;
    logic          hit;
    logic [DW-1:0] hit_data;
    logic          buf_fill;
    logic          buf_park;
    logic          buf_drop;
    logic [DW-1:0] buf_word;
    logic          buf_valid;

    pf_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .cmd_ready   (cmd_ready),
        .buf_valid   (buf_valid),
        .buf_word    (buf_word),
        .busy        (busy),
        .hit         (hit),
        .issue       (issue),
        .issue_we    (issue_we),
        .issue_addr  (issue_addr),
        .issue_wdata (issue_wdata),
        .abort       (abort),
        .buf_fill    (buf_fill),
        .buf_park    (buf_park),
        .buf_drop    (buf_drop),
        .ir_load     (ir_load),
        .ir_word     (ir_word),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .pc          (pc)
    );

    pf_buffer #(.DW(DW)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .fill  (buf_fill),
        .park  (buf_park),
        .drop  (buf_drop),
        .din   (hit_data),
        .word  (buf_word),
        .valid (buf_valid)
    );

    pf_mem_port #(.AW(AW), .DW(DW), .TW(TW)) u_port (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue),
        .issue_we    (issue_we),
        .issue_addr  (issue_addr),
        .issue_wdata (issue_wdata),
        .abort       (abort),
        .mem_ack     (mem_ack),
        .mem_ack_tag (mem_ack_tag),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_tag     (mem_tag),
        .mem_abort   (mem_abort),
        .busy        (busy),
        .hit         (hit),
        .hit_data    (hit_data)
    );

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
    parameter int AW = 16,
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [2:0]    cmd_op,
    input logic [AW-1:0] pc,
    input logic          ir_load,
    input logic          rsp_valid,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [TW-1:0] mem_tag,
    input logic          mem_abort,
    input logic          mem_ack,
    input logic [TW-1:0] mem_ack_tag
);

    logic          seen_req;
    logic          pending;
    logic [TW-1:0] pend_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_req <= 1'b0;
            pending  <= 1'b0;
            pend_tag <= '0;
        end else begin
            if (mem_req) begin
                seen_req <= 1'b1;
            end
            if (mem_abort || (mem_ack && (mem_ack_tag == pend_tag))) begin
                pending <= 1'b0;
            end
            if (mem_req) begin
                pending  <= 1'b1;
                pend_tag <= mem_tag;
            end
        end
    end

    AST_BOOT_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !seen_req) |-> (mem_addr == '0)); // R1

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(ir_load && rsp_valid)); // R2

    AST_PC_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && !cmd_valid) |=> $stable(pc)); // R2

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !pending); // R7

    AST_ABORT_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        mem_abort |-> (pending && !mem_req)); // R8

    AST_REISSUE_AFTER_ABORT: assert property (@(posedge clk) disable iff (rst)
        mem_abort |=> (mem_req && !mem_abort)); // R8

    AST_RESERVED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cmd_op > 3'd4)) |=>
            ($stable(pc) && !ir_load && !rsp_valid)); // R10

endmodule

bind fetch_unit fetch_unit_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .pc          (pc),
    .ir_load     (ir_load),
    .rsp_valid   (rsp_valid),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_tag     (mem_tag),
    .mem_abort   (mem_abort),
    .mem_ack     (mem_ack),
    .mem_ack_tag (mem_ack_tag)
);

// File: tb/test_fetch_unit.sv
module test_fetch_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int TW = 2;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          ir_load;
    logic [DW-1:0] ir_word;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] pc;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [TW-1:0] mem_tag;
    logic          mem_abort;
    logic          mem_ack;
    logic [TW-1:0] mem_ack_tag;
    logic [DW-1:0] mem_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fetch_unit #(.AW(AW), .DW(DW), .TW(TW)) i_fetch_unit (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .ir_load(ir_load), .ir_word(ir_word),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pc(pc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_tag(mem_tag), .mem_abort(mem_abort),
        .mem_ack(mem_ack), .mem_ack_tag(mem_ack_tag), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] seed_word(input int a);
        return DW'((a * 37 + 11) & 8'hFF);
    endfunction

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    logic          m_pend;
    logic [TW-1:0] m_tag;
    logic [AW-1:0] m_addr;
    logic          m_we;
    logic [DW-1:0] m_wdata;
    int            m_cnt;
    int            req_n;
    int            st_cnt;
    logic [TW-1:0] st_tag;
    logic          any_req;
    logic [AW-1:0] first_addr;
    int            abort_n;
    int            stale_n;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]    = seed_word(i);
            shadow[i] = seed_word(i);
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_pend      <= 1'b0;
            mem_ack     <= 1'b0;
            mem_ack_tag <= '0;
            mem_rdata   <= '0;
            st_cnt      <= 0;
            req_n       <= 0;
            any_req     <= 1'b0;
            first_addr  <= '0;
            abort_n     <= 0;
            stale_n     <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_abort) begin
                m_pend  <= 1'b0;
                st_cnt  <= 2;
                st_tag  <= m_tag;
                abort_n <= abort_n + 1;
            end else if (m_pend) begin
                if (m_cnt == 1) begin
                    m_pend      <= 1'b0;
                    mem_ack     <= 1'b1;
                    mem_ack_tag <= m_tag;
                    mem_rdata   <= m_we ? 8'h00 : mem[m_addr];
                    if (m_we) mem[m_addr] <= m_wdata;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
            if (st_cnt == 2) begin
                st_cnt <= 1;
            end else if (st_cnt == 1) begin
                st_cnt      <= 0;
                mem_ack     <= 1'b1;
                mem_ack_tag <= st_tag;
                mem_rdata   <= 8'hEE;
                stale_n     <= stale_n + 1;
            end
            if (mem_req) begin
                m_pend  <= 1'b1;
                m_tag   <= mem_tag;
                m_addr  <= mem_addr;
                m_we    <= mem_we;
                m_wdata <= mem_wdata;
                m_cnt   <= 3 + (req_n % 3);
                req_n   <= req_n + 1;
                if (!any_req) begin
                    any_req    <= 1'b1;
                    first_addr <= mem_addr;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8 reissue and R7 single-outstanding monitors
    logic abort_prev = 1'b0;
    int   overlap_n = 0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (abort_prev) begin
                check("R8 request after abort", {31'd0, mem_req && !mem_abort}, 32'd1);
            end
            if (mem_req && m_pend) overlap_n++;
            abort_prev = mem_abort;
        end
    end

    logic [AW-1:0] exp_pc;
    logic [DW-1:0] last_ir;

    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int gap,
                           output logic got_ir, output logic got_rsp,
                           output logic [DW-1:0] data, output int lat);
        repeat (gap) @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat     = 1;
        got_ir  = 1'b0;
        got_rsp = 1'b0;
        data    = '0;
        if (op > 3'd4) begin
            for (int k = 0; k < 6; k++) begin
                if (ir_load) got_ir = 1'b1;
                if (rsp_valid) got_rsp = 1'b1;
                @(negedge clk);
            end
        end else begin
            while (!ir_load && !rsp_valid && lat < 200) begin
                @(negedge clk);
                lat++;
            end
            got_ir  = ir_load;
            got_rsp = rsp_valid;
            data    = ir_load ? ir_word : rsp_data;
        end
    endtask

    task automatic do_next(input int gap, input string req);
        logic gi, gr;
        logic [DW-1:0] d;
        int l;
        run_cmd(3'd0, '0, '0, gap, gi, gr, d, l);
        check({req, " next ir_load"}, {31'd0, gi}, 32'd1);
        check({req, " next word"}, {24'd0, d}, {24'd0, shadow[exp_pc]});
        exp_pc = exp_pc + 1'b1;
        check({req, " next pc"}, {26'd0, pc}, {26'd0, exp_pc});
        last_ir = d;
    endtask

    initial begin
        logic gi, gr;
        logic [DW-1:0] d;
        int l;
        int wait_n;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 pc in reset", {26'd0, pc}, 32'd0);
        check("R1 ir_load in reset", {31'd0, ir_load}, 32'd0);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 cmd_ready in reset", {31'd0, cmd_ready}, 32'd0);
        rst = 1'b0;
        wait_n = 0;
        while (!ir_load && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        check("R1 boot load", {31'd0, ir_load}, 32'd1);
        check("R1 boot word", {24'd0, ir_word}, {24'd0, shadow[0]});
        check("R1 boot pc", {26'd0, pc}, 32'd1);
        check("R1 first address", {26'd0, first_addr}, 32'd0);
        exp_pc  = 1;
        last_ir = ir_word;

        // R2 sequential cells with varied gaps
        for (int i = 0; i < 20; i++) do_next(i % 4, "R2");

        // R11 buffer already full: two-edge latency
        for (int i = 0; i < 4; i++) begin
            run_cmd(3'd0, '0, '0, 8, gi, gr, d, l);
            check("R11 latency", l, 32'd2);
            check("R11 word", {24'd0, d}, {24'd0, shadow[exp_pc]});
            exp_pc = exp_pc + 1'b1;
            last_ir = d;
        end

        // R3 literals
        for (int i = 0; i < 10; i++) begin
            run_cmd(3'd1, '0, '0, i % 3, gi, gr, d, l);
            check("R3 rsp_valid", {31'd0, gr}, 32'd1);
            check("R3 literal", {24'd0, d}, {24'd0, shadow[exp_pc]});
            exp_pc = exp_pc + 1'b1;
            check("R3 pc", {26'd0, pc}, {26'd0, exp_pc});
            check("R3 ir unchanged", {24'd0, ir_word}, {24'd0, last_ir});
        end

        // R4 read every address, gaps put it before/during/after prefetch
        for (int a = 0; a < DEPTH; a++) begin
            run_cmd(3'd2, AW'(a), '0, a % 4, gi, gr, d, l);
            check("R4 read data", {24'd0, d}, {24'd0, shadow[a]});
            check("R4 pc kept", {26'd0, pc}, {26'd0, exp_pc});
        end
        do_next(2, "R4");

        // R5 overwrite the cell already prefetched, then the one in flight
        run_cmd(3'd3, exp_pc, 8'h3C, 8, gi, gr, d, l);
        check("R5 write done", {31'd0, gr}, 32'd1);
        shadow[exp_pc] = 8'h3C;
        do_next(0, "R5");
        run_cmd(3'd3, exp_pc, 8'hC3, 1, gi, gr, d, l);
        shadow[exp_pc] = 8'hC3;
        run_cmd(3'd1, '0, '0, 0, gi, gr, d, l);
        check("R5 literal after write", {24'd0, d}, {24'd0, shadow[exp_pc]});
        exp_pc = exp_pc + 1'b1;

        // R5 write every address, then read all back
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] v;
            v = DW'(((a * 5) + 3) ^ 8'h5A);
            run_cmd(3'd3, AW'(a), v, a % 3, gi, gr, d, l);
            shadow[a] = v;
        end
        for (int a = 0; a < DEPTH; a++) begin
            run_cmd(3'd2, AW'(a), '0, (a + 1) % 4, gi, gr, d, l);
            check("R5 readback", {24'd0, d}, {24'd0, shadow[a]});
        end

        // R6 jump to every address
        for (int t = 0; t < DEPTH; t++) begin
            run_cmd(3'd4, AW'(t), '0, t % 5, gi, gr, d, l);
            check("R6 jump ir_load", {31'd0, gi}, 32'd1);
            check("R6 jump word", {24'd0, d}, {24'd0, shadow[t]});
            exp_pc = AW'(t + 1);
            check("R6 jump pc", {26'd0, pc}, {26'd0, exp_pc});
            last_ir = d;
        end
        do_next(1, "R6");

        // R10 reserved codes
        for (int c = 5; c < 8; c++) begin
            run_cmd(3'(c), 6'h15, 8'h77, c - 4, gi, gr, d, l);
            check("R10 no ir_load", {31'd0, gi}, 32'd0);
            check("R10 no rsp", {31'd0, gr}, 32'd0);
            check("R10 pc kept", {26'd0, pc}, {26'd0, exp_pc});
            check("R10 ir kept", {24'd0, ir_word}, {24'd0, last_ir});
        end
        do_next(0, "R10");

        // R8/R9/R7 summaries
        check("R8 aborts exercised", {31'd0, abort_n > 0}, 32'd1);
        check("R9 stale acks injected", {31'd0, stale_n > 0}, 32'd1);
        check("R7 no overlapping request", overlap_n, 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule